// File: doc/BRIEF.md
# Real-Time Clock Divider Chain and Rate Selector

This block turns a 32.768 kHz oscillator level, sampled in the system clock domain, into the timing events of a real-time clock. It detects each rising edge of that level and uses it to advance a 15-bit binary divider. A three-bit oscillator control field picks one of three states: running, held in reset, or stopped. A four-bit rate code picks one divider tap. That tap drives both a square-wave output and a one-cycle periodic event.

The divider also produces the once-per-second update strobe. The first strobe comes half a second after the chain leaves reset, and each later strobe comes a whole second after the one before. An update-in-progress flag rises a fixed number of oscillator periods ahead of every strobe. A hold input, used while software rewrites the time, clears that flag. Under the hold, each strobe still reaches the internal counter but is marked as carrying no user transfer. A full-rate override sends the oscillator level itself to the square-wave output.

Top module: `rtc_divchain`

## Requirements
- R1: The control bits osc_mode[2:1] set the divider state: 01 runs the divider, 11 holds it at zero with no events, and any other value stops it, freezing the count and keeping sq_out low. osc_mode[0] has no effect.
- R2: While running, the divider advances by one on each cycle in which xtal_lvl is 1 and was 0 in the cycle before.
- R3: rate_sel picks the tap. Code 0 gives no tap, so there is no periodic event. Code 1 selects 128 oscillator periods and code 2 selects 256. Codes 3 to 15 select periods that double from 4 to 16384 oscillator periods.
- R4: periodic_event is a pulse one system cycle wide that comes once per selected period, in the cycle after the selected tap rises.
- R5: With full_rate at 0, sq_out equals the selected tap when sq_en is 1, and sq_out is low when sq_en is 0.
- R6: With full_rate at 1 and the oscillator not stopped, sq_out is the oscillator level as registered at the last clock edge, whatever rate_sel and sq_en hold.
- R7: update_tick pulses for one cycle 16384 oscillator periods after the divider leaves its held state, and then every 32768 oscillator periods.
- R8: uip rises 8 oscillator periods before each update_tick and falls in the same cycle in which update_tick pulses.
- R9: While set_hold is 1, uip is 0 from the next cycle on, even if it was high. update_tick still pulses and update_xfer stays 0.
- R10: When set_hold is 0, update_xfer pulses together with update_tick and never pulses on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_lvl | input | 1 | 32.768 kHz oscillator level, already synchronized |
| osc_mode | input | 3 | Oscillator/divider control; bit 0 ignored |
| rate_sel | input | 4 | Tap selection code |
| sq_en | input | 1 | Square-wave output enable |
| full_rate | input | 1 | Route undivided oscillator level to sq_out |
| set_hold | input | 1 | Inhibits user transfer and clears uip |
| sq_out | output | 1 | Square-wave output |
| periodic_event | output | 1 | One-cycle pulse per selected period |
| update_tick | output | 1 | Once-per-second update strobe |
| update_xfer | output | 1 | Update strobe that carries a user transfer |
| uip | output | 1 | Update-in-progress flag |

## Verification
Four kinds of error matter most, and the bench looks for each:
- A tap mapping off by one stage would show up as a periodic interval twice or half the expected length, so the bench measures that interval exactly for several rate codes.
- An off-by-one in the half-second release would move the first update_tick by one oscillator period, so its timing is checked to the cycle, as is the 16-cycle lead of uip.
- A design that decoded osc_mode[0] would change the period.
- A design that ignored the hold would leave uip high, or raise update_xfer, during the second update.

The bench also samples the stopped and held states and the full-rate override. Events leaking through there, or a tap level showing through, would flag an error.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

    localparam int CHAIN_W  = 15;
    localparam int RATE_W   = 4;
    localparam int UIP_LEAD = 8;

    typedef enum logic [1:0] {
        OSC_OFF  = 2'd0,
        OSC_RUN  = 2'd1,
        OSC_HOLD = 2'd2
    } osc_state_e;

    typedef struct packed {
        logic tick;
        logic xfer;
        logic uip;
    } upd_status_t;

    // Bit 0 of the control field selects a register bank elsewhere.
    function automatic osc_state_e decode_osc(input logic [2:0] ctl);
        case (ctl[2:1])
            2'b01:   return OSC_RUN;
            2'b11:   return OSC_HOLD;
            default: return OSC_OFF;
        endcase
    endfunction

    // Divider bit whose period is the one selected by the rate code.
    // Bit k of the chain has a period of 2^(k+1) oscillator periods.
    function automatic int unsigned tap_of(input logic [RATE_W-1:0] rs);
        case (rs)
            4'd0:    return 0;
            4'd1:    return 6;
            4'd2:    return 7;
            default: return int'(rs) - 2;
        endcase
    endfunction

endpackage

// File: rtl/rtc_osc_ctl.sv
module rtc_osc_ctl
    import rtc_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       xtal_lvl,
    input  logic [2:0] ctl,
    output osc_state_e state,
    output logic       tick,
    output logic       lvl_q
);

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= xtal_lvl;
    end

    always_comb begin
        state = decode_osc(ctl);
        tick  = (state != OSC_OFF) && xtal_lvl && !lvl_q;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R2

endmodule

// File: rtl/rtc_div_core.sv
module rtc_div_core
    import rtc_div_pkg::*;
#(
    parameter int W    = CHAIN_W,
    parameter int LEAD = UIP_LEAD
) (
    input  logic         clk,
    input  logic         rst,
    input  osc_state_e   state,
    input  logic         tick,
    input  logic         set_hold,
    output logic [W-1:0] chain,
    output upd_status_t  upd
);

    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] WARN = HALF - W'(LEAD);

    logic [W-1:0] nxt;
    logic         adv;

    always_comb begin
        nxt = chain + W'(1);
        adv = (state == OSC_RUN) && tick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            upd   <= '0;
        end else begin
            upd.tick <= 1'b0;
            upd.xfer <= 1'b0;
            case (state)
                OSC_HOLD: begin
                    chain   <= '0;
                    upd.uip <= 1'b0;
                end
                OSC_RUN: begin
                    if (adv) begin
                        chain <= nxt;
                        if (nxt == HALF) begin
                            upd.tick <= 1'b1;
                            upd.xfer <= !set_hold;
                        end
                    end
                    if (set_hold)                   upd.uip <= 1'b0;
                    else if (adv && nxt == WARN)    upd.uip <= 1'b1;
                    else if (adv && nxt == HALF)    upd.uip <= 1'b0;
                end
                default: upd.uip <= 1'b0;
            endcase
        end
    end

    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (state == OSC_HOLD) |=> (chain == '0)); // R1
    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state == OSC_OFF) |=> $stable(chain)); // R1
    AST_UIP_WINDOW: assert property (@(posedge clk) disable iff (rst)
        upd.uip |-> (chain >= WARN && chain < HALF)); // R8
    AST_SET_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        set_hold |=> (!upd.uip && !upd.xfer)); // R9
    AST_XFER_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        upd.xfer |-> upd.tick); // R10

endmodule

// File: rtl/rtc_tap_sel.sv
module rtc_tap_sel
    import rtc_div_pkg::*;
#(
    parameter int W  = CHAIN_W,
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  osc_state_e    state,
    input  logic          tick,
    input  logic [W-1:0]  chain,
    input  logic [RW-1:0] rate_sel,
    input  logic          sq_en,
    input  logic          full_rate,
    input  logic          lvl_q,
    output logic          sq_out,
    output logic          periodic_event
);

    localparam int NCODES = 2 ** RW;

    logic [W-1:0]        nxt;
    logic [NCODES-1:0]   tap_now;
    logic [NCODES-1:0]   tap_nxt;

    assign nxt = chain + W'(1);

    for (genvar r = 0; r < NCODES; r++) begin : g_tap
        if (r == 0) begin : g_off
            assign tap_now[r] = 1'b0;
            assign tap_nxt[r] = 1'b0;
        end else begin : g_on
            assign tap_now[r] = chain[tap_of(RW'(r))];
            assign tap_nxt[r] = nxt[tap_of(RW'(r))];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) periodic_event <= 1'b0;
        else     periodic_event <= (state == OSC_RUN) && tick
                                   && !tap_now[rate_sel] && tap_nxt[rate_sel];
    end

    always_comb begin
        if (state == OSC_OFF)  sq_out = 1'b0;
        else if (full_rate)    sq_out = lvl_q;
        else                   sq_out = sq_en && tap_now[rate_sel];
    end

    AST_PERIODIC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        periodic_event |=> !periodic_event); // R4
    AST_RATE_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == '0) |=> !periodic_event); // R3
    AST_SQ_AT_EVENT: assert property (@(posedge clk) disable iff (rst)
        (periodic_event && sq_en && !full_rate && $stable(rate_sel)) |-> sq_out); // R5

endmodule

// File: rtl/rtc_divchain.sv
module rtc_divchain
    import rtc_div_pkg::*;
#(
    parameter int W    = CHAIN_W,
    parameter int RW   = RATE_W,
    parameter int LEAD = UIP_LEAD
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          xtal_lvl,
    input  logic [2:0]    osc_mode,
    input  logic [RW-1:0] rate_sel,
    input  logic          sq_en,
    input  logic          full_rate,
    input  logic          set_hold,
    output logic          sq_out,
    output logic          periodic_event,
    output logic          update_tick,
    output logic          update_xfer,
    output logic          uip
);

    osc_state_e   state;
    logic         tick;
    logic         lvl_q;
    logic [W-1:0] chain;
    upd_status_t  upd;

    rtc_osc_ctl u_osc (
        .clk   (clk),
        .rst   (rst),
        .xtal_lvl(xtal_lvl),
        .ctl   (osc_mode),
        .state (state),
        .tick  (tick),
        .lvl_q (lvl_q)
    );

    rtc_div_core #(.W(W), .LEAD(LEAD)) u_core (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .tick    (tick),
        .set_hold(set_hold),
        .chain   (chain),
        .upd     (upd)
    );

    rtc_tap_sel #(.W(W), .RW(RW)) u_tap (
        .clk           (clk),
        .rst           (rst),
        .state         (state),
        .tick          (tick),
        .chain         (chain),
        .rate_sel      (rate_sel),
        .sq_en         (sq_en),
        .full_rate     (full_rate),
        .lvl_q         (lvl_q),
        .sq_out        (sq_out),
        .periodic_event(periodic_event)
    );

    assign update_tick = upd.tick;
    assign update_xfer = upd.xfer;
    assign uip         = upd.uip;

    AST_UPDATE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        update_tick |=> !update_tick); // R7
    AST_UIP_FALLS_AT_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (update_tick && !$past(set_hold)) |-> !uip); // R8

endmodule

// File: tb/sim_rtc_divchain.sv
module sim_rtc_divchain;

    localparam int CLK_P    = 10;
    localparam int WD_LIMIT = 180000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xtal_lvl = 1'b0;
    logic [2:0] osc_mode = 3'b110;
    logic [3:0] rate_sel = 4'd0;
    logic       sq_en = 1'b0;
    logic       full_rate = 1'b0;
    logic       set_hold = 1'b0;
    logic       sq_out, periodic_event, update_tick, update_xfer, uip;

    int  checks = 0;
    int  errors = 0;
    int  cycles = 0;
    bit  done   = 1'b0;
    logic lvl_at_edge = 1'b0;

    rtc_divchain u0 (
        .clk(clk), .rst(rst), .xtal_lvl(xtal_lvl), .osc_mode(osc_mode),
        .rate_sel(rate_sel), .sq_en(sq_en), .full_rate(full_rate),
        .set_hold(set_hold), .sq_out(sq_out), .periodic_event(periodic_event),
        .update_tick(update_tick), .update_xfer(update_xfer), .uip(uip)
    );

    always #(CLK_P/2) clk = ~clk;

    // Oscillator level: toggles a quarter period after each rising edge.
    always begin
        @(posedge clk);
        lvl_at_edge = xtal_lvl;
        #(CLK_P/4);
        xtal_lvl = ~xtal_lvl;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WD_LIMIT && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Wait for one periodic pulse, then return cycles to the next one.
    task automatic measure_period(output int gap, output bit wide);
        int t;
        gap = 0; wide = 1'b0;
        t = 0;
        do begin step(1); t++; end while (!periodic_event && t < 5000);
        step(1);
        if (periodic_event) wide = 1'b1;
        gap = 1;
        while (!periodic_event && gap < 5000) begin step(1); gap++; end
    endtask

    task automatic t_reset();
        rst = 1'b1; osc_mode = 3'b110;
        step(4);
        check("R1 reset sq_out", sq_out, 0);
        check("R1 reset periodic", periodic_event, 0);
        check("R7 reset update_tick", update_tick, 0);
        check("R10 reset update_xfer", update_xfer, 0);
        check("R8 reset uip", uip, 0);
        rst = 1'b0;
        step(2);
    endtask

    task automatic t_hold();
        int ev = 0, hi = 0;
        osc_mode = 3'b110; rate_sel = 4'd3; sq_en = 1'b1;
        for (int i = 0; i < 200; i++) begin
            step(1);
            ev += int'(periodic_event); hi += int'(sq_out);
        end
        check("R1 hold: periodic events", ev, 0);
        check("R1 hold: sq_out high cycles", hi, 0);
    endtask

    task automatic t_rate(input logic [2:0] mode, input logic [3:0] rs,
                          input int exp_gap, input string req);
        int gap; bit wide;
        osc_mode = mode; rate_sel = rs;
        measure_period(gap, wide);
        measure_period(gap, wide);
        check({req, " period cycles"}, gap, exp_gap);
        check("R4 pulse width one cycle", wide, 0);
    endtask

    task automatic t_rate_zero();
        int ev = 0, hi = 0;
        osc_mode = 3'b010; rate_sel = 4'd0; sq_en = 1'b1;
        for (int i = 0; i < 600; i++) begin
            step(1);
            ev += int'(periodic_event); hi += int'(sq_out);
        end
        check("R3 code 0 periodic events", ev, 0);
        check("R5 code 0 sq_out high", hi, 0);
    endtask

    task automatic t_square();
        int gap; bit wide; int hi = 0;
        osc_mode = 3'b010; rate_sel = 4'd3; sq_en = 1'b1; full_rate = 1'b0;
        measure_period(gap, wide);
        step(7);
        for (int i = 0; i < 64; i++) begin step(1); hi += int'(sq_out); end
        check("R5 tap duty high cycles of 64", hi, 32);
        sq_en = 1'b0; hi = 0;
        for (int i = 0; i < 64; i++) begin step(1); hi += int'(sq_out); end
        check("R5 sq_en 0 high cycles", hi, 0);
    endtask

    task automatic t_full();
        int bad = 0;
        osc_mode = 3'b010; full_rate = 1'b1; sq_en = 1'b0; rate_sel = 4'd0;
        step(1);
        for (int i = 0; i < 40; i++) begin
            step(1);
            if (sq_out !== lvl_at_edge) bad++;
        end
        check("R6 full rate mismatches", bad, 0);
        sq_en = 1'b1; rate_sel = 4'd9; bad = 0;
        for (int i = 0; i < 40; i++) begin
            step(1);
            if (sq_out !== lvl_at_edge) bad++;
        end
        check("R6 full rate ignores rs/sq_en", bad, 0);
        full_rate = 1'b0;
    endtask

    task automatic t_off();
        int ev = 0, hi = 0;
        osc_mode = 3'b001; rate_sel = 4'd3; sq_en = 1'b1; full_rate = 1'b1;
        for (int i = 0; i < 200; i++) begin
            step(1);
            ev += int'(periodic_event); hi += int'(sq_out);
        end
        full_rate = 1'b0;
        for (int i = 0; i < 200; i++) begin
            step(1);
            ev += int'(periodic_event); hi += int'(sq_out);
        end
        check("R1 stopped periodic events", ev, 0);
        check("R1 stopped sq_out high", hi, 0);
    endtask

    task automatic t_update();
        int n = 0, rise = -1, upd_at;
        osc_mode = 3'b110; set_hold = 1'b0; rate_sel = 4'd0;
        step(10);
        osc_mode = 3'b010;
        do begin
            step(1); n++;
            if (uip && rise < 0) rise = n;
        end while (!update_tick && n < 40000);
        upd_at = n;
        check("R7 first update within window", int'(n >= 32767 && n <= 32768), 1);
        check("R8 uip lead cycles", upd_at - rise, 16);
        check("R8 uip low at update", uip, 0);
        check("R10 xfer with update", update_xfer, 1);
        // Second update: raise the hold once uip is high.
        n = 0;
        do begin step(1); n++; end while (!uip && n < 70000);
        check("R8 uip rises before second update", n, 65536 - 16);
        set_hold = 1'b1;
        step(1); n++;
        check("R9 uip cleared by hold", uip, 0);
        while (!update_tick && n < 70000) begin
            step(1); n++;
            if (uip) begin
                errors++; checks++;
                $display("FAIL R9 uip high under hold: actual 1 expected 0");
            end
        end
        check("R7 update spacing cycles", n, 65536);
        check("R9 xfer under hold", update_xfer, 0);
        set_hold = 1'b0;
    endtask

    initial begin
        t_reset();
        t_hold();
        t_rate(3'b010, 4'd3, 8,   "R3 code 3");
        t_rate(3'b010, 4'd6, 64,  "R3 code 6");
        t_rate(3'b010, 4'd1, 256, "R3 code 1");
        t_rate(3'b010, 4'd2, 512, "R3 code 2");
        t_rate(3'b011, 4'd3, 8,   "R1 bank bit set, R2 advance");
        t_rate_zero();
        t_square();
        t_full();
        t_off();
        t_update();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule